// File: doc/BRIEF.md
# Flash block erase-verify sequencer

This block is a hardware sequencer that erases the blocks of a flash macro one at a time and proves each erase by reading every word back. Software hands it a mask of pending blocks and a start pulse. The sequencer raises the global write-enable, picks the lowest pending block, and arms the external watchdog. It then walks the erase-setup, erase and exit steps, each held for a configured number of clock cycles. After that it enters verify mode and, for each word, writes all-ones and reads the word back.

A word that does not read back as all ones ends verify mode and restarts the erase of that block, up to a configured number of erase passes. When every pending block is clean, or when a block runs out of passes, the sequencer drops write-enable and reports done, with a fail flag and the index of the failing block. All waits come from configuration inputs in clock cycles. A value of 0 is treated as 1. There is no pre-programming pass before an erase.

Top module: `flash_erase_seq`

## Requirements
- R1: After reset every flash control output, the watchdog strobes, `busy_o`, `done_o` and `fail_o` are 0.
- R2: The first block select of a run rises exactly `cfg_we_i`+1 cycles after `fl_swe_o` rises: `cfg_we_i` cycles of settle plus one cycle to choose a block. A block select is only ever high while `fl_swe_o` is high.
- R3: `fl_sel_o` is one-hot or zero. Only blocks set in the latched mask are selected, and bit i selects block i, taken in ascending index order.
- R4: Before each erase pass, `wdt_load_o` pulses for one cycle while erase-setup is low. The pulse carries `wdt_val_o` = `cfg_esu_i`+`cfg_ers_i`+`cfg_hold_i`+`cfg_wdc_i`+1.
- R5: Erase-setup is high for exactly `cfg_esu_i` cycles before the erase line rises, and the erase line is never high without erase-setup.
- R6: The erase line stays high for exactly `cfg_ers_i` cycles per pass.
- R7: After the erase line falls, erase-setup stays high for `cfg_hold_i` cycles. `wdt_clr_o` pulses on the `cfg_wdc_i`-th cycle after erase-setup falls, which is the last cycle before verify mode starts.
- R8: The verify line is high only while erase and erase-setup are low. The first dummy write comes `cfg_evs_i` cycles after verify rises. Every dummy write (`fl_we_o`) carries data 16'hFFFF. The read strobe (`fl_re_o`) for the same address comes `cfg_rd_i`+1 cycles after the write.
- R9: Verify walks word addresses 0 to WORDS-1 in ascending order. `fl_addr_o` = {block index, word index}, so with the defaults bits [4:3] hold the block and bits [2:0] hold the word.
- R10: A word that reads other than 16'hFFFF ends verify mode and restarts the block from the watchdog load. Once `cfg_tries_i` erase passes of a block have failed, the run ends with `fail_o`=1 and `fail_blk_o` = that block, and no later block is touched.
- R11: When all pending blocks verify, `done_o`=1, `fail_o`=0, `busy_o`=0 and `fl_swe_o`=0. Done and fail hold until the next start.
- R12: A start pulse while `busy_o` is high is ignored. The mask then presented has no effect on the run.
- R13: A start with an empty mask completes with `done_o`=1 and `fail_o`=0, and no block is ever selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start request, taken only when idle |
| blk_mask_i | input | NBLK | Blocks to erase, latched at start |
| cfg_we_i | input | CW | Write-enable settle before block select |
| cfg_esu_i | input | CW | Erase-setup time before erase |
| cfg_ers_i | input | CW | Erase pulse length |
| cfg_hold_i | input | CW | Erase-setup hold after erase falls |
| cfg_wdc_i | input | CW | Delay from erase-setup fall to watchdog clear |
| cfg_evs_i | input | CW | Verify settle before the first dummy write |
| cfg_rd_i | input | CW | Gap between dummy write and read |
| cfg_evx_i | input | CW | Wait after leaving verify mode |
| cfg_tries_i | input | RW | Maximum erase passes per block |
| fl_swe_o | output | 1 | Global flash write-enable |
| fl_esu_o | output | 1 | Erase-setup |
| fl_e_o | output | 1 | Erase |
| fl_ev_o | output | 1 | Erase-verify |
| fl_sel_o | output | NBLK | One-hot block select |
| fl_addr_o | output | AW | Word address {block, word} |
| fl_wdata_o | output | DW | Dummy write data |
| fl_we_o | output | 1 | Dummy write strobe |
| fl_re_o | output | 1 | Verify read strobe |
| fl_rdata_i | input | DW | Read data, valid in the cycle of the read strobe |
| wdt_load_o | output | 1 | Watchdog load strobe |
| wdt_val_o | output | CW+3 | Watchdog timeout value |
| wdt_clr_o | output | 1 | Watchdog clear strobe |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | Run finished |
| fail_o | output | 1 | Run ended on an unerasable block |
| fail_blk_o | output | BIW | Index of the failing block |

## Verification
The hardest case to reach from the ports is a word that fails verify partway through a block, followed by a re-erase that then succeeds. A second hard case is a block that never comes clean and so exhausts its erase passes while later blocks are still pending. The bench's flash model counts the erase pulses each block receives. It returns a word with one zero bit at a chosen address until that block has had a chosen number of pulses, so both the partial walk and the pass limit are reached on purpose. The same run also presents a second start with a wider mask while busy, to show the extra blocks are never selected.

// File: rtl/fes_pkg.sv
package fes_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_SWE,
        S_NEXT,
        S_SEL,
        S_ESU,
        S_ERASE,
        S_HOLD,
        S_WDC,
        S_EVSET,
        S_DWR,
        S_RDW,
        S_READ,
        S_EVX,
        S_FIN
    } fes_state_e;

endpackage

// File: rtl/fes_wait_timer.sv
module fes_wait_timer #(
    parameter int CW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic [CW-1:0] val_i,
    output logic          expired_o
);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i) begin
            cnt_d = val_i;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign expired_o = (cnt_q == '0);

    // R6: once run out, the count stays at zero until reloaded
    a_r6_timer_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (expired_o && !load_i) |=> expired_o);

endmodule

// File: rtl/fes_block_pick.sv
module fes_block_pick #(
    parameter int NBLK = 4,
    parameter int BIW  = 2
) (
    input  logic [NBLK-1:0] mask_i,
    output logic            valid_o,
    output logic [BIW-1:0]  idx_o
);

    always_comb begin
        idx_o = '0;
        for (int i = NBLK - 1; i >= 0; i--) begin
            if (mask_i[i]) begin
                idx_o = BIW'(i);
            end
        end
    end

    assign valid_o = |mask_i;

endmodule

// File: rtl/flash_erase_seq.sv
module flash_erase_seq
    import fes_pkg::*;
#(
    parameter int NBLK  = 4,
    parameter int WORDS = 8,
    parameter int CW    = 12,
    parameter int RW    = 4,
    parameter int DW    = 16,
    localparam int BIW  = (NBLK > 1) ? $clog2(NBLK) : 1,
    localparam int WAW  = (WORDS > 1) ? $clog2(WORDS) : 1,
    localparam int AW   = BIW + WAW,
    localparam int WDW  = CW + 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start_i,
    input  logic [NBLK-1:0] blk_mask_i,
    input  logic [CW-1:0]   cfg_we_i,
    input  logic [CW-1:0]   cfg_esu_i,
    input  logic [CW-1:0]   cfg_ers_i,
    input  logic [CW-1:0]   cfg_hold_i,
    input  logic [CW-1:0]   cfg_wdc_i,
    input  logic [CW-1:0]   cfg_evs_i,
    input  logic [CW-1:0]   cfg_rd_i,
    input  logic [CW-1:0]   cfg_evx_i,
    input  logic [RW-1:0]   cfg_tries_i,
    output logic            fl_swe_o,
    output logic            fl_esu_o,
    output logic            fl_e_o,
    output logic            fl_ev_o,
    output logic [NBLK-1:0] fl_sel_o,
    output logic [AW-1:0]   fl_addr_o,
    output logic [DW-1:0]   fl_wdata_o,
    output logic            fl_we_o,
    output logic            fl_re_o,
    input  logic [DW-1:0]   fl_rdata_i,
    output logic            wdt_load_o,
    output logic [WDW-1:0]  wdt_val_o,
    output logic            wdt_clr_o,
    output logic            busy_o,
    output logic            done_o,
    output logic            fail_o,
    output logic [BIW-1:0]  fail_blk_o
);

    localparam logic [WAW-1:0] LAST_WORD = WAW'(WORDS - 1);

    typedef struct packed {
        fes_state_e      st;
        logic [NBLK-1:0] pend;
        logic [BIW-1:0]  blk;
        logic [WAW-1:0]  word;
        logic [RW-1:0]   tries;
        logic            retry;
        logic            fail_p;
        logic            done;
        logic            fail;
        logic [BIW-1:0]  fail_blk;
    } seq_t;

    seq_t q, d;

    logic           tmr_load;
    logic [CW-1:0]  tmr_val;
    logic [CW-1:0]  dur;
    logic           tmr_exp;
    logic           pick_valid;
    logic [BIW-1:0] pick_idx;
    logic [NBLK-1:0] sel_vec;
    logic           in_blk;

    fes_wait_timer #(.CW(CW)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (tmr_load),
        .val_i     (tmr_val),
        .expired_o (tmr_exp)
    );

    fes_block_pick #(.NBLK(NBLK), .BIW(BIW)) u_pick (
        .mask_i  (q.pend),
        .valid_o (pick_valid),
        .idx_o   (pick_idx)
    );

    // next-state computation
    always_comb begin
        d = q;
        unique case (q.st)
            S_IDLE: begin
                if (start_i) begin
                    d.pend     = blk_mask_i;
                    d.done     = 1'b0;
                    d.fail     = 1'b0;
                    d.fail_blk = '0;
                    d.fail_p   = 1'b0;
                    d.st       = S_SWE;
                end
            end
            S_SWE:   if (tmr_exp) d.st = S_NEXT;
            S_NEXT: begin
                if (q.fail_p || !pick_valid) begin
                    d.st = S_FIN;
                end else begin
                    d.blk   = pick_idx;
                    d.tries = '0;
                    d.word  = '0;
                    d.st    = S_SEL;
                end
            end
            S_SEL: begin
                d.tries = q.tries + 1'b1;
                d.retry = 1'b0;
                d.word  = '0;
                d.st    = S_ESU;
            end
            S_ESU:   if (tmr_exp) d.st = S_ERASE;
            S_ERASE: if (tmr_exp) d.st = S_HOLD;
            S_HOLD:  if (tmr_exp) d.st = S_WDC;
            S_WDC:   if (tmr_exp) d.st = S_EVSET;
            S_EVSET: if (tmr_exp) d.st = S_DWR;
            S_DWR:   d.st = S_RDW;
            S_RDW:   if (tmr_exp) d.st = S_READ;
            S_READ: begin
                if (fl_rdata_i == '1) begin
                    if (q.word == LAST_WORD) begin
                        d.st = S_EVX;
                    end else begin
                        d.word = q.word + 1'b1;
                        d.st   = S_DWR;
                    end
                end else begin
                    if (q.tries >= cfg_tries_i) begin
                        d.fail_p   = 1'b1;
                        d.fail_blk = q.blk;
                    end else begin
                        d.retry = 1'b1;
                    end
                    d.st = S_EVX;
                end
            end
            S_EVX: begin
                if (tmr_exp) begin
                    if (q.retry) begin
                        d.st = S_SEL;
                    end else begin
                        if (!q.fail_p) d.pend[q.blk] = 1'b0;
                        d.st = S_NEXT;
                    end
                end
            end
            S_FIN: begin
                d.done   = 1'b1;
                d.fail   = q.fail_p;
                d.fail_p = 1'b0;
                d.st     = S_IDLE;
            end
            default: d.st = S_IDLE;
        endcase
    end

    // wait length of the state being entered
    always_comb begin
        unique case (d.st)
            S_SWE:   dur = cfg_we_i;
            S_ESU:   dur = cfg_esu_i;
            S_ERASE: dur = cfg_ers_i;
            S_HOLD:  dur = cfg_hold_i;
            S_WDC:   dur = cfg_wdc_i;
            S_EVSET: dur = cfg_evs_i;
            S_RDW:   dur = cfg_rd_i;
            S_EVX:   dur = cfg_evx_i;
            default: dur = '0;
        endcase
        tmr_load = (d.st != q.st);
        tmr_val  = (dur == '0) ? '0 : dur - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.st       <= S_IDLE;
            q.pend     <= '0;
            q.blk      <= '0;
            q.word     <= '0;
            q.tries    <= '0;
            q.retry    <= 1'b0;
            q.fail_p   <= 1'b0;
            q.done     <= 1'b0;
            q.fail     <= 1'b0;
            q.fail_blk <= '0;
        end else begin
            q <= d;
        end
    end

    // output decode
    for (genvar g = 0; g < NBLK; g++) begin : g_sel
        assign sel_vec[g] = (q.blk == BIW'(g));
    end

    assign in_blk     = !(q.st inside {S_IDLE, S_SWE, S_NEXT, S_FIN});
    assign fl_swe_o   = !(q.st inside {S_IDLE, S_FIN});
    assign fl_sel_o   = in_blk ? sel_vec : '0;
    assign fl_esu_o   = q.st inside {S_ESU, S_ERASE, S_HOLD};
    assign fl_e_o     = (q.st == S_ERASE);
    assign fl_ev_o    = q.st inside {S_EVSET, S_DWR, S_RDW, S_READ};
    assign fl_we_o    = (q.st == S_DWR);
    assign fl_re_o    = (q.st == S_READ);
    assign fl_wdata_o = fl_we_o ? '1 : '0;
    assign fl_addr_o  = {q.blk, q.word};
    assign wdt_load_o = (q.st == S_SEL);
    assign wdt_val_o  = WDW'(cfg_esu_i) + WDW'(cfg_ers_i) + WDW'(cfg_hold_i)
                      + WDW'(cfg_wdc_i) + WDW'(1);
    assign wdt_clr_o  = (q.st == S_WDC) && tmr_exp;
    assign busy_o     = (q.st != S_IDLE);
    assign done_o     = q.done;
    assign fail_o     = q.fail;
    assign fail_blk_o = q.fail_blk;

    // erase pulse length tracker for the bound check
    logic [CW-1:0] e_run_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            e_run_q <= '0;
        end else begin
            e_run_q <= fl_e_o ? e_run_q + 1'b1 : '0;
        end
    end

    a_r3_sel_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(fl_sel_o));
    a_r2_sel_needs_swe: assert property (@(posedge clk) disable iff (!rst_n)
        (|fl_sel_o) |-> fl_swe_o);
    a_r5_e_needs_esu: assert property (@(posedge clk) disable iff (!rst_n)
        fl_e_o |-> fl_esu_o);
    a_r6_e_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        fl_e_o |-> ((cfg_ers_i == '0) || (e_run_q < cfg_ers_i)));
    a_r8_ev_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        fl_ev_o |-> (!fl_esu_o && !fl_e_o));
    a_r8_write_in_verify: assert property (@(posedge clk) disable iff (!rst_n)
        fl_we_o |-> (fl_ev_o && fl_wdata_o == '1));
    a_r11_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!busy_o && !fl_swe_o));
    a_r4_load_before_esu: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_load_o |=> fl_esu_o);

endmodule

// File: tb/flash_erase_seq_tb.sv
module flash_erase_seq_tb;

    localparam int NBLK = 4;
    localparam int WORDS = 8;
    localparam int CW = 12;
    localparam int RW = 4;
    localparam int DW = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic            start = 1'b0;
    logic [NBLK-1:0] blk_mask = '0;
    logic [CW-1:0]   c_we, c_esu, c_ers, c_hold, c_wdc, c_evs, c_rd, c_evx;
    logic [RW-1:0]   c_tries;
    logic            swe, esu, e, ev, we, re, wload, wclr, busy, done, fail;
    logic [NBLK-1:0] sel;
    logic [4:0]      addr;
    logic [DW-1:0]   wdata, rdata;
    logic [CW+2:0]   wval;
    logic [1:0]      fblk;

    flash_erase_seq u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start), .blk_mask_i(blk_mask),
        .cfg_we_i(c_we), .cfg_esu_i(c_esu), .cfg_ers_i(c_ers), .cfg_hold_i(c_hold),
        .cfg_wdc_i(c_wdc), .cfg_evs_i(c_evs), .cfg_rd_i(c_rd), .cfg_evx_i(c_evx),
        .cfg_tries_i(c_tries),
        .fl_swe_o(swe), .fl_esu_o(esu), .fl_e_o(e), .fl_ev_o(ev), .fl_sel_o(sel),
        .fl_addr_o(addr), .fl_wdata_o(wdata), .fl_we_o(we), .fl_re_o(re),
        .fl_rdata_i(rdata), .wdt_load_o(wload), .wdt_val_o(wval), .wdt_clr_o(wclr),
        .busy_o(busy), .done_o(done), .fail_o(fail), .fail_blk_o(fblk)
    );

    // flash model state: ecnt written by monitor, base/need/badw by driver
    int ecnt [NBLK];
    int base [NBLK];
    int need [NBLK];
    int badw [NBLK];
    int exp_q [$];

    always_comb begin
        int b;
        int w;
        b = int'(addr[4:3]);
        w = int'(addr[2:0]);
        rdata = (w == badw[b] && (ecnt[b] - base[b]) < need[b]) ? 16'hFBFF : 16'hFFFF;
    end

    int mon_err = 0, mon_chk = 0, drv_err = 0, drv_chk = 0, wd_err = 0;

    task automatic chk_m(input bit ok, input string req, input int act, input int expv);
        mon_chk++;
        if (!ok) begin
            mon_err++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    task automatic chk_d(input bit ok, input string req, input int act, input int expv);
        drv_chk++;
        if (!ok) begin
            drv_err++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    // monitor: timing rules and scoreboard of verify reads
    int cyc = 0, t_swe = 0, t_esu = 0, t_e = 0, t_ef = 0, t_esf = 0, t_ev = 0, t_w = 0;
    int w_addr = 0, epulse = 0, sel_cyc = 0;
    bit first_sel = 0, first_w = 0;
    logic p_swe = 0, p_esu = 0, p_e = 0, p_ev = 0, p_sel = 0;

    initial for (int b = 0; b < NBLK; b++) ecnt[b] = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            cyc++;
            if (swe && !p_swe) begin t_swe = cyc; first_sel = 1; end
            if ((|sel) && !p_sel && first_sel) begin
                chk_m(cyc - t_swe == int'(c_we) + 1, "R2 select delay", cyc - t_swe, int'(c_we) + 1);
                first_sel = 0;
            end
            if (|sel) sel_cyc++;
            if (wload)
                chk_m(!esu && int'(wval) == int'(c_esu + c_ers + c_hold + c_wdc) + 1,
                      "R4 watchdog load", int'(wval), int'(c_esu + c_ers + c_hold + c_wdc) + 1);
            if (esu && !p_esu) t_esu = cyc;
            if (e && !p_e) begin
                chk_m(cyc - t_esu == int'(c_esu), "R5 setup time", cyc - t_esu, int'(c_esu));
                t_e = cyc;
                epulse++;
                for (int b = 0; b < NBLK; b++) if (sel[b]) ecnt[b]++;
            end
            if (!e && p_e) begin
                chk_m(cyc - t_e == int'(c_ers), "R6 erase length", cyc - t_e, int'(c_ers));
                t_ef = cyc;
            end
            if (!esu && p_esu) begin
                chk_m(cyc - t_ef == int'(c_hold), "R7 setup hold", cyc - t_ef, int'(c_hold));
                t_esf = cyc;
            end
            if (wclr)
                chk_m(cyc - t_esf == int'(c_wdc) - 1, "R7 watchdog clear", cyc - t_esf, int'(c_wdc) - 1);
            if (ev && !p_ev) begin t_ev = cyc; first_w = 1; end
            if (we) begin
                chk_m(wdata == 16'hFFFF, "R8 dummy data", int'(wdata), 16'hFFFF);
                if (first_w) chk_m(cyc - t_ev == int'(c_evs), "R8 verify settle", cyc - t_ev, int'(c_evs));
                first_w = 0;
                t_w = cyc;
                w_addr = int'(addr);
            end
            if (re) begin
                chk_m(cyc - t_w == int'(c_rd) + 1 && int'(addr) == w_addr, "R8 read gap",
                      cyc - t_w, int'(c_rd) + 1);
                if (exp_q.size() == 0) begin
                    chk_m(0, "R3 R9 unexpected read", int'(addr), -1);
                end else begin
                    int x;
                    x = exp_q.pop_front();
                    chk_m(int'(addr) == x, "R3 R9 read address", int'(addr), x);
                end
            end
            p_swe = swe; p_esu = esu; p_e = e; p_ev = ev; p_sel = |sel;
        end
    end

    // driver: computes expected reads and outcome, then runs the block
    task automatic run_scn(input logic [3:0] mask, input logic [3:0] mid_mask, input bit mid);
        int ep = 0, fb = 0, mx, p0, s0, n = 0;
        bit fexp = 0;
        mx = (c_tries == 0) ? 1 : int'(c_tries);
        for (int b = 0; b < NBLK; b++) base[b] = ecnt[b];
        for (int b = 0; b < NBLK; b++) begin
            if (mask[b] && !fexp) begin
                for (int a = 1; a <= 16; a++) begin
                    ep++;
                    if (a < need[b]) begin
                        for (int w = 0; w <= badw[b]; w++) exp_q.push_back(b * WORDS + w);
                        if (a >= mx) begin fexp = 1; fb = b; break; end
                    end else begin
                        for (int w = 0; w < WORDS; w++) exp_q.push_back(b * WORDS + w);
                        break;
                    end
                end
            end
        end
        p0 = epulse;
        s0 = sel_cyc;
        @(negedge clk); start = 1'b1; blk_mask = mask;
        @(negedge clk); start = 1'b0;
        if (mid) begin
            repeat (30) @(negedge clk);
            start = 1'b1; blk_mask = mid_mask;
            @(negedge clk); start = 1'b0;
        end
        while (busy && n < 50000) begin @(negedge clk); n++; end
        chk_d(done == 1'b1, "R11 done", int'(done), 1);
        chk_d(swe == 1'b0, "R11 write-enable cleared", int'(swe), 0);
        chk_d(fail == fexp, "R10 fail flag", int'(fail), int'(fexp));
        if (fexp) chk_d(int'(fblk) == fb, "R10 failing block", int'(fblk), fb);
        chk_d(epulse - p0 == ep, "R10 erase pass count", epulse - p0, ep);
        chk_d(exp_q.size() == 0, mid ? "R12 start ignored while busy" : "R9 all words read",
              exp_q.size(), 0);
        if (mask == 0) chk_d(sel_cyc == s0, "R13 no block selected", sel_cyc - s0, 0);
        exp_q.delete();
    endtask

    task automatic set_cfg(input int we_, input int esu_, input int ers_, input int hold_,
                           input int wdc_, input int evs_, input int rd_, input int evx_,
                           input int tr_);
        c_we = CW'(we_); c_esu = CW'(esu_); c_ers = CW'(ers_); c_hold = CW'(hold_);
        c_wdc = CW'(wdc_); c_evs = CW'(evs_); c_rd = CW'(rd_); c_evx = CW'(evx_);
        c_tries = RW'(tr_);
    endtask

    task automatic set_flash(input int n0, input int n1, input int n2, input int n3,
                             input int b0, input int b1, input int b2, input int b3);
        need[0] = n0; need[1] = n1; need[2] = n2; need[3] = n3;
        badw[0] = b0; badw[1] = b1; badw[2] = b2; badw[3] = b3;
    endtask

    initial begin
        int limit = 150000;
        repeat (limit) @(negedge clk);
        wd_err = 1;
        $display("FAIL watchdog: actual=%0d expected=%0d", limit, 0);
        $display("Result: errors=%0d of %0d checks", mon_err + drv_err + wd_err,
                 mon_chk + drv_chk + wd_err);
        $finish;
    end

    initial begin
        set_cfg(3, 4, 6, 2, 3, 2, 2, 3, 3);
        set_flash(1, 1, 1, 1, 0, 0, 0, 0);
        for (int b = 0; b < NBLK; b++) base[b] = 0;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk_d({swe, esu, e, ev, we, re, wload, wclr, busy, done, fail} == '0 && sel == '0,
              "R1 reset outputs", int'({swe, esu, e, ev, we, re, wload, wclr, busy, done, fail}), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk_d(busy == 1'b0 && done == 1'b0, "R1 idle after reset", int'(busy), 0);

        // single clean block
        run_scn(4'b0001, 4'b0000, 0);
        // two blocks, block 1 needs a re-erase failing at word 3
        set_flash(1, 2, 1, 1, 0, 3, 0, 0);
        run_scn(4'b1010, 4'b1111, 1);
        // block 1 never clean within the pass limit; block 2 must stay untouched
        set_flash(1, 9, 1, 1, 0, 5, 0, 0);
        run_scn(4'b0110, 4'b0000, 0);
        // empty mask
        run_scn(4'b0000, 4'b0000, 0);
        // different timing, single pass allowed, all blocks clean
        set_cfg(1, 1, 9, 1, 1, 1, 1, 1, 1);
        set_flash(1, 1, 1, 1, 0, 0, 0, 0);
        run_scn(4'b1111, 4'b0000, 0);
        // last word of block 0 dirty with a one-pass limit
        set_flash(2, 1, 1, 1, 7, 0, 0, 0);
        run_scn(4'b0011, 4'b0000, 0);

        $display("Result: errors=%0d of %0d checks", mon_err + drv_err + wd_err,
                 mon_chk + drv_chk + wd_err);
        $finish;
    end

endmodule